// File: doc/BRIEF.md
# Stepper Phase Sequence Generator

This block produces the phase and enable bits for the two full bridges of a two-phase bipolar stepper motor. It walks a ring of eight positions. Each rising edge on a step input moves it one position, and a direction input chooses which way it moves. Current regulation and the switching of the bridge transistors happen elsewhere. This block only decides which coil is energised and in which polarity.

The step input may come from outside the clock domain. It passes through a synchroniser and an edge detector before it reaches the state register. A mode input selects between two step sizes. With the mode high, every position of the ring is visited (half stepping). With the mode low, each step jumps two positions. In that case the parity of the current position decides the drive style: odd-numbered positions energise both coils, and even-numbered positions energise one coil. The style is therefore chosen by the position the ring holds when the mode input goes low. An active-low reset returns the ring to position 1.

Top module: `step_sequencer`

## Requirements
- R1: While `rst_n` is low, the position is forced to 1 and stays there after release. Outputs: `step_pos`=0 (position minus one), `en_a`=1, `en_b`=1, `phase_a`=1, `phase_b`=1.
- R2: Each rising edge of `step_in` moves the position exactly once. The move appears on the third rising clock edge after `step_in` rises. Holding `step_in` high produces no further moves.
- R3: With `half_sel`=1 and `cw`=1, a step moves from position n to n+1, wrapping from 8 to 1.
- R4: With `half_sel`=1 and `cw`=0, a step moves from position n to n-1, wrapping from 1 to 8.
- R5: With `half_sel`=0 from an odd position, a step moves two positions: 1,3,5,7 when `cw`=1 and 1,7,5,3 when `cw`=0.
- R6: With `half_sel`=0 from an even position, a step moves two positions: 2,4,6,8 when `cw`=1 and 8,6,4,2 when `cw`=0. Resetting, stepping once with `half_sel`=1 and `cw`=1, and then lowering `half_sel` gives the sequence 2,4,6,...
- R7: In odd positions both `en_a` and `en_b` are 1. In even positions exactly one of them is 1.
- R8: The phase bit is 1 for positive and 0 for negative. A disabled bridge drives its phase bit 0. The positions map as follows: 1 = A+ B+, 2 = B+ only, 3 = A- B+, 4 = A- only, 5 = A- B-, 6 = B- only, 7 = A+ B-, 8 = A+ only.
- R9: A synchronous reset wins over a step edge that is detected in the same clock cycle.
- R10: `cw` and `half_sel` are sampled only when a step edge is detected. Changing them with no step edge leaves the position and the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset to position 1 |
| step_in | input | 1 | Step request, asynchronous, acts on its rising edge |
| cw | input | 1 | Direction: 1 = increasing positions, 0 = decreasing |
| half_sel | input | 1 | 1 = one-position steps, 0 = two-position steps |
| phase_a | output | 1 | Bridge A polarity, 1 = positive |
| en_a | output | 1 | Bridge A enable |
| phase_b | output | 1 | Bridge B polarity, 1 = positive |
| en_b | output | 1 | Bridge B enable |
| step_pos | output | 3 | Current position minus one (0..7) |

## Verification
The embedded properties check on every cycle the following:
- the position holds with no detected edge;
- detected edges never come back to back;
- a one-position step moves by exactly one in the requested direction;
- a two-position step keeps parity;
- the enable count matches the parity of the position.

Some behaviour only the bench scenarios can show: the exact synchroniser latency, the full mapping from positions to phases, the entry into one-coil drive through the mode input, and a reset that collides with a pending edge.

// File: rtl/step_sequencer.sv
module step_sequencer #(
  parameter int SYNC_STAGES = 2,
  parameter int POS_W       = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_in,
  input  logic             cw,
  input  logic             half_sel,
  output logic             phase_a,
  output logic             en_a,
  output logic             phase_b,
  output logic             en_b,
  output logic [POS_W-1:0] step_pos
);
  localparam int SMSB = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   step_prev;
  logic [POS_W-1:0]       pos_q;
  logic [POS_W-1:0]       stride;
  logic                   step_edge;
  logic [1:0]             quad;
  logic                   single;

  assign step_edge = sync_q[SMSB] & ~step_prev;
  assign stride    = half_sel ? POS_W'(1) : POS_W'(2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q    <= '0;
      step_prev <= 1'b0;
      pos_q     <= '0;
    end else begin
      sync_q    <= {sync_q[SMSB-1:0], step_in};
      step_prev <= sync_q[SMSB];
      if (step_edge)
        pos_q <= cw ? pos_q + stride : pos_q - stride;
    end
  end

  // even index = two coils, odd index = one coil
  assign single = pos_q[0];
  assign quad   = pos_q[2:1];

  always_comb begin
    if (!single) begin
      en_a    = 1'b1;
      en_b    = 1'b1;
      phase_a = (quad == 2'd0) || (quad == 2'd3);
      phase_b = (quad == 2'd0) || (quad == 2'd1);
    end else begin
      en_a    = quad[0];
      en_b    = ~quad[0];
      phase_a = (quad == 2'd3);
      phase_b = (quad == 2'd0);
    end
  end

  assign step_pos = pos_q;

  p_hold_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !step_edge |=> $stable(step_pos));

  p_one_move_per_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    step_edge |=> !step_edge);

  p_half_fwd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step_edge && half_sel && cw |=> step_pos == POS_W'($past(step_pos) + 1));

  p_half_rev_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_edge && half_sel && !cw |=> step_pos == POS_W'($past(step_pos) - 1));

  p_full_parity_r5: assert property (@(posedge clk) disable iff (!rst_n)
    step_edge && !half_sel |=> (step_pos[0] == $past(step_pos[0])) && (step_pos != $past(step_pos)));

  p_enable_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({en_a, en_b}) == (step_pos[0] ? 1 : 2));
endmodule

// File: tb/step_sequencer_bench.sv
module step_sequencer_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic step_in = 1'b0;
  logic cw = 1'b1;
  logic half_sel = 1'b1;
  logic phase_a, en_a, phase_b, en_b;
  logic [2:0] step_pos;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  step_sequencer u_step_sequencer (
    .clk(clk), .rst_n(rst_n), .step_in(step_in), .cw(cw), .half_sel(half_sel),
    .phase_a(phase_a), .en_a(en_a), .phase_b(phase_b), .en_b(en_b), .step_pos(step_pos)
  );

  // {cw, half_sel, expected index}
  localparam logic [4:0] VEC [NVEC] = '{
    {1'b1,1'b1,3'd1}, {1'b1,1'b1,3'd2}, {1'b1,1'b1,3'd3},
    {1'b0,1'b1,3'd2}, {1'b0,1'b1,3'd1}, {1'b0,1'b1,3'd0}, {1'b0,1'b1,3'd7},
    {1'b1,1'b0,3'd1}, {1'b1,1'b0,3'd3}, {1'b0,1'b0,3'd1}, {1'b0,1'b0,3'd7},
    {1'b1,1'b1,3'd0}, {1'b1,1'b0,3'd2}, {1'b1,1'b0,3'd4}, {1'b1,1'b0,3'd6},
    {1'b1,1'b0,3'd0}, {1'b0,1'b0,3'd6}
  };

  // R8 mapping: {phase_a, en_a, phase_b, en_b}
  function automatic logic [3:0] exp_out(input logic [2:0] idx);
    case (idx)
      3'd0: return 4'b1111;
      3'd1: return 4'b0011;
      3'd2: return 4'b0111;
      3'd3: return 4'b0100;
      3'd4: return 4'b0101;
      3'd5: return 4'b0001;
      3'd6: return 4'b1101;
      default: return 4'b1100;
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic check_pos(input string req, input logic [2:0] idx);
    check(req, {5'd0, step_pos}, {5'd0, idx});
    check({req, " outputs"}, {4'd0, phase_a, en_a, phase_b, en_b}, {4'd0, exp_out(idx)});
  endtask

  task automatic pulse(input logic d, input logic h);
    @(negedge clk);
    cw = d; half_sel = h; step_in = 1'b1;
    repeat (4) @(negedge clk);
    step_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; step_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_pos("R1 home after reset", 3'd0);

    for (int i = 0; i < NVEC; i++) begin
      pulse(VEC[i][4], VEC[i][3]);
      check_pos($sformatf("R3/R4/R5/R6/R8 vector %0d", i), VEC[i][2:0]);
      check("R7 enable count", 8'(en_a + en_b), VEC[i][0] ? 8'd1 : 8'd2);
    end

    // R10: toggling cw and half_sel with no step edge
    cw = ~cw; @(negedge clk); half_sel = ~half_sel; repeat (3) @(negedge clk);
    check_pos("R10 no move without edge", 3'd6);

    // R2: latency and a held-high input
    do_reset();
    cw = 1'b1; half_sel = 1'b1; step_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R2 not yet moved", {5'd0, step_pos}, 8'd0);
    @(negedge clk);
    check("R2 moved on third edge", {5'd0, step_pos}, 8'd1);
    repeat (10) @(negedge clk);
    check("R2 held high moves once", {5'd0, step_pos}, 8'd1);
    step_in = 1'b0; repeat (4) @(negedge clk);

    // R9: reset on the cycle the edge is detected
    step_in = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b0; step_in = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_pos("R9 reset beats edge", 3'd0);

    // R6: one-coil entry procedure
    do_reset();
    pulse(1'b1, 1'b1);
    check_pos("R6 entry half step", 3'd1);
    pulse(1'b1, 1'b0);
    check_pos("R6 wave 4", 3'd3);
    pulse(1'b1, 1'b0);
    check_pos("R6 wave 6", 3'd5);

    // R5: normal drive from reset, reverse order
    do_reset();
    pulse(1'b0, 1'b0);
    check_pos("R5 reverse to 7", 3'd6);
    pulse(1'b0, 1'b0);
    check_pos("R5 reverse to 5", 3'd4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule